// File: doc/BRIEF.md
# Phase-Error Lock Detector with Output Mute

This block decides whether a phase-locked loop has settled. The reference and feedback edges from the phase detector arrive as one-cycle pulses on a fast sampling clock. The block times each reference edge against the feedback edge that follows it. A reference cycle counts as good when the feedback edge comes fewer than `THRESH` sample-clock cycles after the reference edge. With the default 400 MHz sampling clock, a `THRESH` of 6 corresponds to 15 ns.

The block counts good reference cycles in an unbroken run. It declares lock once that run reaches 3, or 5 when the precision input is high. A single bad cycle clears the run and drops the lock flag. The lock flag also gates an RF output enable. While the mute control is set, the enable stays low until lock is declared. While mute is clear, the enable depends only on the power-down input. Power-down clears all of the detector state.

All ports are plain control and status signals. The edge inputs are single-cycle pulses and carry no handshake. The block cannot apply back-pressure, so a pulse is acted on in the cycle it is high and is never held waiting.

Top module: `pll_lock_mute`

## Requirements
- R1: A reference cycle is good when the feedback pulse arrives d sample cycles after the reference pulse with d < THRESH. d = 0 means both pulses are high in the same cycle.
- R2: If no feedback pulse has arrived by d = THRESH, the cycle is judged bad in that cycle. A feedback pulse that arrives exactly at d = THRESH also makes the cycle bad.
- R3: A reference pulse that arrives while the previous window is still open with no feedback pulse makes that cycle bad. The new pulse then opens a fresh window.
- R4: `locked` is high while the run of consecutive good cycles is at least 3 when `precise`=0, or at least 5 when `precise`=1. It responds at once to a change of `precise`. It rises only in the cycle after a good cycle ends, or after a change of `precise`.
- R5: A bad cycle resets the run to zero. `locked` is low from the cycle after the bad cycle is detected.
- R6: The run saturates at 5. Further good cycles keep `locked` high.
- R7: While `pwr_dn`=1, `locked` and `rf_en` are low in the same cycle. The run and any open window are cleared, and edge pulses are ignored.
- R8: With `mute_en`=1, `rf_en` equals `locked`. With `mute_en`=0, `rf_en` equals NOT `pwr_dn`.
- R9: After reset, `locked` is low and no window is open. A feedback pulse with no reference pulse before it produces no good cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_edge | input | 1 | One-cycle pulse on each reference edge |
| fb_edge | input | 1 | One-cycle pulse on each feedback edge |
| precise | input | 1 | Run length for lock: 0 needs 3 good cycles, 1 needs 5 |
| mute_en | input | 1 | 1 holds rf_en low until lock is declared |
| pwr_dn | input | 1 | Synchronous power-down; clears the detector |
| locked | output | 1 | Lock flag |
| rf_en | output | 1 | RF output enable |

## Verification
The bench places the feedback pulse one cycle on either side of the threshold. A detector that is off by one in its window count would accept the late edge or reject the edge that is just in time. A short reference period with no feedback pulse checks that the stale window is judged bad. A design that let the run carry over that window would lock one cycle early. Other tests lower `precise` while the run is at 4, and raise power-down while the block is locked. Then a single good cycle follows power-down, and feedback pulses arrive with no reference pulse. These catch a lock flag that was latched instead of compared, a run that survived power-down, and a window opened by the wrong edge.

// File: rtl/pll_lock_mute_pkg.sv
package pll_lock_mute_pkg;
  // Outcome of one reference window, as seen by the run counter
  typedef enum logic [1:0] {
    WIN_NONE = 2'd0,
    WIN_GOOD = 2'd1,
    WIN_BAD  = 2'd2
  } win_ev_t;
endpackage

// File: rtl/plm_phase_window.sv
// Times the reference-to-feedback gap and reports one outcome per window.
module plm_phase_window
  import pll_lock_mute_pkg::*;
#(
  parameter int THRESH = 6
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    clr,
  input  logic    ref_edge,
  input  logic    fb_edge,
  output win_ev_t ev
);
  localparam int CW = (THRESH > 2) ? $clog2(THRESH) : 1;
  localparam logic [CW-1:0] LAST = CW'(THRESH - 1);

  logic          open_q;
  logic [CW-1:0] gap_q;

  // Old window is judged first; a lone ref+fb pair is a zero-gap good cycle
  always_comb begin
    ev = WIN_NONE;
    if (open_q) begin
      if (gap_q == LAST)  ev = WIN_BAD;
      else if (fb_edge)   ev = WIN_GOOD;
      else if (ref_edge)  ev = WIN_BAD;
    end else if (ref_edge && fb_edge) begin
      ev = WIN_GOOD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      gap_q  <= '0;
    end else if (clr) begin
      open_q <= 1'b0;
      gap_q  <= '0;
    end else if (ref_edge && (open_q || !fb_edge)) begin
      open_q <= 1'b1;
      gap_q  <= '0;
    end else if (open_q && ev != WIN_NONE) begin
      open_q <= 1'b0;
      gap_q  <= '0;
    end else if (open_q) begin
      gap_q  <= gap_q + CW'(1);
    end
  end
endmodule

// File: rtl/plm_run_counter.sv
// Counts consecutive good windows and compares against the selected length.
module plm_run_counter
  import pll_lock_mute_pkg::*;
#(
  parameter int RUN_LO = 3,
  parameter int RUN_HI = 5,
  localparam int SW = $clog2(RUN_HI + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  win_ev_t       ev,
  input  logic          precise,
  output logic [SW-1:0] run,
  output logic          reached
);
  localparam logic [SW-1:0] LO = SW'(RUN_LO);
  localparam logic [SW-1:0] HI = SW'(RUN_HI);

  logic [SW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            run_q <= '0;
    else if (clr || ev == WIN_BAD)         run_q <= '0;
    else if (ev == WIN_GOOD && run_q < HI) run_q <= run_q + SW'(1);
  end

  assign run     = run_q;
  assign reached = run_q >= (precise ? HI : LO);
endmodule

// File: rtl/pll_lock_mute.sv
module pll_lock_mute
  import pll_lock_mute_pkg::*;
#(
  parameter int THRESH = 6,
  parameter int RUN_LO = 3,
  parameter int RUN_HI = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_edge,
  input  logic fb_edge,
  input  logic precise,
  input  logic mute_en,
  input  logic pwr_dn,
  output logic locked,
  output logic rf_en
);
  localparam int SW = $clog2(RUN_HI + 1);

  win_ev_t       win_ev;
  logic [SW-1:0] run_cnt;
  logic          run_ok;

  plm_phase_window #(.THRESH(THRESH)) u_window (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (pwr_dn),
    .ref_edge (ref_edge),
    .fb_edge  (fb_edge),
    .ev       (win_ev)
  );

  plm_run_counter #(.RUN_LO(RUN_LO), .RUN_HI(RUN_HI)) u_run (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (pwr_dn),
    .ev      (win_ev),
    .precise (precise),
    .run     (run_cnt),
    .reached (run_ok)
  );

  assign locked = run_ok && !pwr_dn;
  assign rf_en  = !pwr_dn && (!mute_en || locked);
endmodule

// File: rtl/pll_lock_mute_chk.sv
module pll_lock_mute_chk #(
  parameter int RUN_HI = 5,
  parameter int SW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fb_edge,
  input logic          precise,
  input logic          mute_en,
  input logic          pwr_dn,
  input logic          locked,
  input logic          rf_en,
  input logic [SW-1:0] run
);
  AST_PD_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |-> (!locked && !rf_en)); // R7

  AST_PD_CLEARS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pwr_dn) |-> (run == '0)); // R7

  AST_MUTE_HOLDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (mute_en && !locked) |-> !rf_en); // R8

  AST_UNMUTED_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (!mute_en && !pwr_dn) |-> rf_en); // R8

  AST_LOCK_AFTER_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(locked) && $stable(precise)) |-> $past(fb_edge)); // R4

  AST_RUN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    run <= SW'(RUN_HI)); // R6
endmodule

bind pll_lock_mute pll_lock_mute_chk #(.RUN_HI(RUN_HI), .SW(SW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .fb_edge (fb_edge),
  .precise (precise),
  .mute_en (mute_en),
  .pwr_dn  (pwr_dn),
  .locked  (locked),
  .rf_en   (rf_en),
  .run     (run_cnt)
);

// File: tb/pll_lock_mute_bench.sv
module pll_lock_mute_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PER = 16;      // reference period in sample cycles
  localparam int NO_FB = 99;    // marker: no feedback pulse in the period

  typedef struct packed {
    logic       pr;
    logic       mu;
    logic [6:0] d;
    logic       lk;
    logic       rf;
  } vec_t;

  // THRESH = 6: d <= 5 good, d >= 6 bad
  localparam vec_t VEC [12] = '{
    '{1'b0, 1'b1, 7'd2,  1'b0, 1'b0},  // R1 run 1
    '{1'b0, 1'b1, 7'd5,  1'b0, 1'b0},  // R1 edge just inside, run 2
    '{1'b0, 1'b1, 7'd1,  1'b1, 1'b1},  // R4 run 3 locks, R8 unmuted
    '{1'b0, 1'b1, 7'd6,  1'b0, 1'b0},  // R2 edge at threshold, R5 drop
    '{1'b0, 1'b1, 7'd0,  1'b0, 1'b0},  // R1 zero gap, run 1
    '{1'b0, 1'b1, 7'd3,  1'b0, 1'b0},  // run 2
    '{1'b0, 1'b1, 7'd4,  1'b1, 1'b1},  // R4 run 3
    '{1'b1, 1'b1, 7'd2,  1'b0, 1'b0},  // R4 precise needs 5, run 4
    '{1'b1, 1'b1, 7'd2,  1'b1, 1'b1},  // R4 run 5
    '{1'b1, 1'b1, 7'd99, 1'b0, 1'b0},  // R2 missing feedback, R5
    '{1'b1, 1'b0, 7'd3,  1'b0, 1'b1},  // R8 unmuted while unlocked
    '{1'b1, 1'b0, 7'd7,  1'b0, 1'b1}   // R2 late edge, R8
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_edge = 1'b0, fb_edge = 1'b0;
  logic precise = 1'b0, mute_en = 1'b1, pwr_dn = 1'b0;
  logic locked, rf_en;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_lock_mute u_pll_lock_mute (
    .clk(clk), .rst_n(rst_n), .ref_edge(ref_edge), .fb_edge(fb_edge),
    .precise(precise), .mute_en(mute_en), .pwr_dn(pwr_dn),
    .locked(locked), .rf_en(rf_en)
  );

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // One reference pulse, feedback d cycles later, per cycles long, then one idle cycle
  task automatic run_period(int d, int per);
    for (int i = 0; i < per; i++) begin
      @(negedge clk);
      ref_edge = (i == 0);
      fb_edge  = (i == d);
    end
    @(negedge clk);
    ref_edge = 1'b0;
    fb_edge  = 1'b0;
  endtask

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 locked in reset", locked, 1'b0);
    check("R8 rf_en muted in reset", rf_en, 1'b0);
    mute_en = 1'b0; #1;
    check("R8 rf_en unmuted in reset", rf_en, 1'b1);
    mute_en = 1'b1;
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 locked after reset", locked, 1'b0);

    // R9: feedback pulses with no reference open no window
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); fb_edge = 1'b1;
      @(negedge clk); fb_edge = 1'b0;
    end
    run_period(2, PER);
    run_period(2, PER);
    check("R9 lone feedback not counted", locked, 1'b0);
    run_period(NO_FB, PER);   // clear the run before the table

    for (int v = 0; v < 12; v++) begin
      precise = VEC[v].pr;
      mute_en = VEC[v].mu;
      run_period(int'(VEC[v].d), PER);
      check($sformatf("R1/R2/R4/R5/R8 row %0d locked", v), locked, VEC[v].lk);
      check($sformatf("R8 row %0d rf_en", v), rf_en, VEC[v].rf);
    end

    // R3: reference arrives again before feedback, in a short period
    precise = 1'b0; mute_en = 1'b1;
    run_period(NO_FB, PER);
    run_period(2, PER);
    run_period(2, PER);
    run_period(NO_FB, 3);     // second ref lands while this window is open
    run_period(2, PER);
    check("R3 stale window resets run", locked, 1'b0);
    run_period(2, PER);
    run_period(2, PER);
    check("R3 fresh window counted", locked, 1'b1);

    // R7: power-down while locked
    mute_en = 1'b0;
    @(negedge clk); pwr_dn = 1'b1; #1;
    check("R7 locked low in power-down", locked, 1'b0);
    check("R7 rf_en low in power-down", rf_en, 1'b0);
    run_period(2, PER);
    check("R7 edges ignored in power-down", locked, 1'b0);
    pwr_dn = 1'b0; #1;
    check("R8 rf_en back when unmuted", rf_en, 1'b1);
    run_period(2, PER);
    check("R7 run cleared by power-down", locked, 1'b0);
    run_period(2, PER);
    run_period(2, PER);
    check("R7 relock after power-down", locked, 1'b1);

    // R4: precise change acts at once
    mute_en = 1'b1; precise = 1'b1;
    run_period(NO_FB, PER);
    for (int k = 0; k < 4; k++) run_period(3, PER);
    check("R4 run 4 short of 5", locked, 1'b0);
    @(negedge clk); precise = 1'b0; #1;
    check("R4 lower threshold locks at once", locked, 1'b1);
    check("R8 rf_en follows lock", rf_en, 1'b1);

    // R6: saturation keeps lock
    precise = 1'b1;
    for (int k = 0; k < 4; k++) run_period(1, PER);
    check("R6 saturated run still locked", locked, 1'b1);

    // R5: drop exactly one cycle after the late edge is judged
    @(negedge clk); ref_edge = 1'b1;
    @(negedge clk); ref_edge = 1'b0;
    repeat (5) @(negedge clk);
    check("R5 still locked before threshold", locked, 1'b1);
    @(negedge clk);
    check("R5 dropped after bad cycle", locked, 1'b0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule